// File: doc/BRIEF.md
# Double-Buffered Asynchronous Serial Receiver

This block takes asynchronous serial frames from a single input line and turns them into bytes for a processor. A shift register builds each frame one bit at a time. The finished byte is then moved into a separate holding register. Because of this split, software can read the waiting byte while the next frame is still coming in.

An external baud generator supplies a one-cycle sampling enable for each bit period. The block samples the line only in cycles where that enable is high. Data length (7 or 8 bits) and parity (off, even or odd) are set by static configuration inputs. These inputs must not change while a frame is in progress.

The processor sees the held byte, a buffer-full flag, a parity-error flag and an overrun flag. It drops both the buffer-full and overrun flags with a one-cycle read strobe. Each time a byte lands in the holding register, a one-cycle request pulse goes out to an interrupt controller or DMA engine.

Top module: `serial_rx_dbuf`

## Requirements
- R1: After reset, `rx_byte`, `byte_ready`, `parity_bad`, `lost_byte` and `rx_req` are all 0. A sampling enable that sees the line high while the receiver is idle starts no frame.
- R2: A sampling enable that sees the line low while idle takes that sample as the start bit. Each later sampling enable shifts in one data bit, least significant bit first.
- R3: With `len7_sel` = 0 a frame carries 8 data bits. With `len7_sel` = 1 it carries 7, and bit 7 of `rx_byte` reads 0.
- R4: With `par_on` = 1, the sample after the last data bit is taken as the parity bit. With `par_on` = 0 there is no parity slot, and the next sample is the stop bit.
- R5: `parity_bad` is latched together with each transferred byte. It is 1 only when `par_on` = 1 and the count of ones in the data bits plus the parity bit is odd while `par_odd` = 0 (even parity), or even while `par_odd` = 1 (odd parity).
- R6: At the sampling enable of the first stop bit, the assembled byte moves into the holding register. `byte_ready` reads 1 from that clock edge on. A second stop bit is not waited for, so the next start bit can be taken at the very next sampling enable.
- R7: `rx_req` is high for exactly one cycle: the first cycle in which each newly transferred byte is visible.
- R8: A cycle with `rd_stb` = 1 and no transfer clears `byte_ready` and `lost_byte`. It leaves `rx_byte` unchanged.
- R9: While a frame is being shifted in, `rx_byte` and `byte_ready` keep their previous values until the stop-bit transfer.
- R10: A transfer while `byte_ready` = 1 with no read in that cycle overwrites `rx_byte` with the new byte and sets `lost_byte` to 1.
- R11: A transfer in the same cycle as `rd_stb` = 1 loads the new byte, leaves `byte_ready` at 1, and clears `lost_byte`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| samp_en | input | 1 | One-cycle sampling enable per bit period from the baud generator |
| rxd | input | 1 | Serial data line, already synchronized to `clk`, idle high |
| len7_sel | input | 1 | 1 selects 7 data bits, 0 selects 8 |
| par_on | input | 1 | 1 enables the parity bit and its check |
| par_odd | input | 1 | 1 selects odd parity, 0 selects even |
| rd_stb | input | 1 | One-cycle processor read strobe for the holding register |
| rx_byte | output | 8 | Holding register contents |
| byte_ready | output | 1 | Holding register contains an unread byte |
| parity_bad | output | 1 | Parity error of the byte in `rx_byte` |
| lost_byte | output | 1 | An unread byte was overwritten |
| rx_req | output | 1 | One-cycle interrupt/DMA request on each transfer |

## Verification
The bench aims at these corner cases:

- **Back-to-back frames with no gap after the first stop bit.** A receiver that waits for a second stop bit would take the next start bit as a stop and lose that frame.
- **A read in the very cycle of a transfer.** A wrong priority here would either drop `byte_ready` on a fresh byte or flag a false overrun.
- **Overwriting an unread byte.** A receiver that gets this wrong would keep the stale byte or miss `lost_byte`.
- **Corrupted parity bits in both even and odd modes.** An inverted sense would show as a wrong `parity_bad`.
- **Frames in 7-bit mode.** A wrong bit count would shift the byte, or put the stop bit into bit 7.
- **Sampling the holding register in the middle of a frame.** This exposes any design that disturbs the holding register before the stop-bit transfer.

// File: rtl/serial_rx_pkg.sv
// Package: shared types for the serial receiver.
// Assumes: nothing beyond IEEE 1800-2017.
package serial_rx_pkg;
    typedef enum logic [1:0] {
        RX_IDLE   = 2'd0,
        RX_DATA   = 2'd1,
        RX_PARITY = 2'd2,
        RX_STOP   = 2'd3
    } rx_phase_e;
endpackage

// File: rtl/rx_frame_shifter.sv
// Module: frame sequencer and shift register.
// Tracks the frame phase, shifts data bits in LSB first, captures the
// parity bit, and pulses frame_done when the first stop bit is sampled.
// Assumes: rxd is synchronous to clk, and the configuration inputs stay
// stable while a frame is in progress.
module rx_frame_shifter
    import serial_rx_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              samp_en,
    input  logic              rxd,
    input  logic              short_len,
    input  logic              par_on,
    output logic [DATA_W-1:0] frame_data,
    output logic              frame_pbit,
    output logic              frame_done
);
    localparam int CNT_W = $clog2(DATA_W);
    localparam logic [CNT_W-1:0] LAST_LONG  = CNT_W'(DATA_W - 1);
    localparam logic [CNT_W-1:0] LAST_SHORT = CNT_W'(DATA_W - 2);

    rx_phase_e         phase;
    logic [CNT_W-1:0]  bit_cnt;
    logic [DATA_W-1:0] shreg;
    logic              last_bit;

    // Index of the last data bit for the configured length.
    assign last_bit = (bit_cnt == (short_len ? LAST_SHORT : LAST_LONG));

    // Phase sequencing and bit capture, advanced only on sampling enables.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase      <= RX_IDLE;
            bit_cnt    <= '0;
            shreg      <= '0;
            frame_pbit <= 1'b0;
        end else if (samp_en) begin
            case (phase)
                RX_IDLE: begin
                    if (!rxd) begin
                        phase   <= RX_DATA;
                        bit_cnt <= '0;
                    end
                end
                RX_DATA: begin
                    shreg   <= {rxd, shreg[DATA_W-1:1]};
                    bit_cnt <= bit_cnt + 1'b1;
                    if (last_bit) phase <= par_on ? RX_PARITY : RX_STOP;
                end
                RX_PARITY: begin
                    frame_pbit <= rxd;
                    phase      <= RX_STOP;
                end
                default: phase <= RX_IDLE;
            endcase
        end
    end

    // Align a short frame to the LSB; the unused top bit is forced to 0.
    assign frame_data = short_len ? {1'b0, shreg[DATA_W-1:1]} : shreg;
    // Transfer strobe: the first stop bit is being sampled.
    assign frame_done = samp_en && (phase == RX_STOP);

    // R1: the sequencer only moves on sampling enables.
    a_r1_hold_between_samples: assert property (@(posedge clk) disable iff (!rst_n)
        !samp_en |=> $stable(phase) && $stable(shreg));
    // R1: a high line seen while idle starts no frame.
    a_r1_idle_high_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == RX_IDLE && samp_en && rxd) |=> phase == RX_IDLE);
    // R6: the receiver returns to idle right after the first stop bit.
    a_r6_first_stop_ends: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |=> phase == RX_IDLE);
endmodule

// File: rtl/rx_parity_check.sv
// Module: combinational parity checker.
// Flags an error when the data and parity bits together do not have the
// parity the mode asks for. Assumes the unused data bits are zero.
module rx_parity_check #(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] data,
    input  logic              pbit,
    input  logic              par_on,
    input  logic              par_odd,
    output logic              perr
);
    logic ones_odd;

    // Reduction XOR: 1 when the count of ones is odd.
    always_comb begin
        ones_odd = ^{data, pbit};
        perr     = par_on && (ones_odd != par_odd);
    end
endmodule

// File: rtl/rx_hold_buffer.sv
// Module: receive holding register and its status flags.
// Loads on a transfer strobe and clears the full and overrun flags on a
// read strobe. When both arrive in the same cycle, the read consumes the
// old byte and the new byte stays pending.
module rx_hold_buffer #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] load_data,
    input  logic              load_perr,
    input  logic              rd_stb,
    output logic [DATA_W-1:0] hold_data,
    output logic              full,
    output logic              perr,
    output logic              ovr,
    output logic              req
);
    // Holding register, parity error and request pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_data <= '0;
            perr      <= 1'b0;
            req       <= 1'b0;
        end else begin
            req <= load;
            if (load) begin
                hold_data <= load_data;
                perr      <= load_perr;
            end
        end
    end

    // Full and overrun flags with read-versus-load priority.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            full <= 1'b0;
            ovr  <= 1'b0;
        end else if (load) begin
            full <= 1'b1;
            ovr  <= full && !rd_stb;
        end else if (rd_stb) begin
            full <= 1'b0;
            ovr  <= 1'b0;
        end
    end

    // R7: a request is only seen together with a full buffer.
    a_r7_req_with_full: assert property (@(posedge clk) disable iff (!rst_n)
        req |-> full);
    // R8: a read with no load empties the buffer and keeps the data.
    a_r8_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && !load) |=> !full && !ovr && $stable(hold_data));
    // R10: a load onto an unread byte flags an overrun.
    a_r10_overrun_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (load && full && !rd_stb) |=> ovr && full);
    // R11: a load that meets a read keeps the buffer full with no overrun.
    a_r11_read_meets_load: assert property (@(posedge clk) disable iff (!rst_n)
        (load && rd_stb) |=> full && !ovr);
endmodule

// File: rtl/serial_rx_dbuf.sv
// Module: double-buffered asynchronous serial receiver (top).
// Connects the frame shifter, the parity checker and the holding buffer.
// Assumes: samp_en is a one-cycle pulse per bit period, rxd is already
// synchronized, and the configuration inputs change only while idle.
module serial_rx_dbuf #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              samp_en,
    input  logic              rxd,
    input  logic              len7_sel,
    input  logic              par_on,
    input  logic              par_odd,
    input  logic              rd_stb,
    output logic [DATA_W-1:0] rx_byte,
    output logic              byte_ready,
    output logic              parity_bad,
    output logic              lost_byte,
    output logic              rx_req
);
    logic [DATA_W-1:0] frame_data;
    logic              frame_pbit;
    logic              frame_done;
    logic              frame_perr;

    rx_frame_shifter #(.DATA_W(DATA_W)) u_shift (
        .clk        (clk),
        .rst_n      (rst_n),
        .samp_en    (samp_en),
        .rxd        (rxd),
        .short_len  (len7_sel),
        .par_on     (par_on),
        .frame_data (frame_data),
        .frame_pbit (frame_pbit),
        .frame_done (frame_done)
    );

    rx_parity_check #(.DATA_W(DATA_W)) u_par (
        .data    (frame_data),
        .pbit    (frame_pbit),
        .par_on  (par_on),
        .par_odd (par_odd),
        .perr    (frame_perr)
    );

    rx_hold_buffer #(.DATA_W(DATA_W)) u_hold (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (frame_done),
        .load_data (frame_data),
        .load_perr (frame_perr),
        .rd_stb    (rd_stb),
        .hold_data (rx_byte),
        .full      (byte_ready),
        .perr      (parity_bad),
        .ovr       (lost_byte),
        .req       (rx_req)
    );

    // R3: a 7-bit frame never sets the top bit of the held byte.
    a_r3_short_msb_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_done && len7_sel) |=> !rx_byte[DATA_W-1]);
    // R5: with parity disabled no parity error is latched.
    a_r5_no_check_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_done && !par_on) |=> !parity_bad);
    // R6: the stop-bit sample makes the buffer full at that edge.
    a_r6_full_after_stop: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |=> byte_ready && rx_req);
endmodule

// File: tb/tb_serial_rx_dbuf.sv
module tb_serial_rx_dbuf;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       samp_en = 1'b0;
    logic       rxd = 1'b1;
    logic       len7_sel = 1'b0;
    logic       par_on = 1'b0;
    logic       par_odd = 1'b0;
    logic       rd_stb = 1'b0;
    logic [7:0] rx_byte;
    logic       byte_ready;
    logic       parity_bad;
    logic       lost_byte;
    logic       rx_req;

    int n_chk = 0;
    int n_bad = 0;
    logic [7:0] m_data = 8'h00;
    logic       m_full = 1'b0;
    logic       m_ovr  = 1'b0;
    logic       m_perr = 1'b0;

    always #4 clk = ~clk;

    serial_rx_dbuf dut (
        .clk(clk), .rst_n(rst_n), .samp_en(samp_en), .rxd(rxd),
        .len7_sel(len7_sel), .par_on(par_on), .par_odd(par_odd),
        .rd_stb(rd_stb), .rx_byte(rx_byte), .byte_ready(byte_ready),
        .parity_bad(parity_bad), .lost_byte(lost_byte), .rx_req(rx_req)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Bench model: parity bit that makes the frame correct.
    function automatic logic good_pbit(input logic [7:0] d, input logic odd);
        return (^d) ^ odd;
    endfunction

    // Bench model: payload after length truncation.
    function automatic logic [7:0] trunc(input logic [7:0] d, input logic l7);
        return l7 ? (d & 8'h7F) : d;
    endfunction

    // One sampled bit: optional gap, then one enable cycle; returns after the edge.
    task automatic samp(input logic b, input logic rd, input bit gap);
        if (gap) repeat ($urandom_range(0, 2)) @(negedge clk);
        @(negedge clk);
        rxd = b; samp_en = 1'b1; rd_stb = rd;
        @(negedge clk);
        samp_en = 1'b0; rd_stb = 1'b0;
    endtask

    task automatic do_read();
        @(negedge clk); rd_stb = 1'b1;
        @(negedge clk); rd_stb = 1'b0;
        m_full = 1'b0; m_ovr = 1'b0;
        check("R8 ready after read", byte_ready, 0);
        check("R8 overrun after read", lost_byte, 0);
        check("R8 data kept", rx_byte, m_data);
    endtask

    task automatic send_frame(input logic [7:0] d, input logic pe, input logic po,
                              input logic l7, input logic corrupt, input logic rd_same,
                              input int nstop, input int idle_hi, input bit gap);
        logic [7:0] pd;
        int nb;
        pd = trunc(d, l7);
        nb = l7 ? 7 : 8;
        @(negedge clk); par_on = pe; par_odd = po; len7_sel = l7;
        for (int i = 0; i < idle_hi; i++) samp(1'b1, 1'b0, gap);
        if (idle_hi > 0) check("R1 idle high no frame", byte_ready, m_full);
        samp(1'b0, 1'b0, gap);
        for (int i = 0; i < nb; i++) begin
            samp(pd[i], 1'b0, gap);
            if (i == 3) begin
                check("R9 data held mid-frame", rx_byte, m_data);
                check("R9 ready held mid-frame", byte_ready, m_full);
            end
        end
        if (pe) samp(good_pbit(pd, po) ^ corrupt, 1'b0, gap);
        samp(1'b1, rd_same, gap);
        m_ovr  = m_full && !rd_same;
        m_full = 1'b1;
        m_data = pd;
        m_perr = pe && corrupt;
        check("R2/R3 byte", rx_byte, m_data);
        check("R6 ready at first stop", byte_ready, 1);
        check("R5 parity flag", parity_bad, m_perr);
        check(rd_same ? "R11 overrun with read" : "R10 overrun", lost_byte, m_ovr);
        check("R7 request high", rx_req, 1);
        @(negedge clk);
        check("R7 request one cycle", rx_req, 0);
        if (nstop == 2) samp(1'b1, 1'b0, gap);
    endtask

    initial begin
        #(8 * 200000);
        n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'h1D5E_ED01));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 reset byte", rx_byte, 0);
        check("R1 reset ready", byte_ready, 0);
        check("R1 reset parity", parity_bad, 0);
        check("R1 reset overrun", lost_byte, 0);
        check("R1 reset request", rx_req, 0);

        // R2/R3: plain 8-bit frame, LSB first, with high samples before the start bit.
        send_frame(8'hA5, 0, 0, 0, 0, 0, 1, 3, 0);
        do_read();
        // R3: 7-bit frame drops bit 7.
        send_frame(8'hFF, 0, 0, 1, 0, 0, 1, 0, 0);
        do_read();
        // R4/R5: even and odd parity, good and corrupted.
        send_frame(8'h3C, 1, 0, 0, 0, 0, 1, 0, 0);
        do_read();
        send_frame(8'h3C, 1, 0, 0, 1, 0, 1, 0, 0);
        do_read();
        send_frame(8'h81, 1, 1, 0, 0, 0, 1, 0, 0);
        do_read();
        send_frame(8'h81, 1, 1, 1, 1, 0, 1, 0, 0);
        do_read();
        // R6: back-to-back frames, start bit right after the first stop bit.
        send_frame(8'h12, 0, 0, 0, 0, 0, 1, 0, 0);
        // R10: overwrite of the unread byte.
        send_frame(8'h34, 1, 0, 0, 0, 0, 1, 0, 0);
        // R11: read in the same cycle as the transfer.
        send_frame(8'h56, 0, 0, 0, 0, 1, 2, 0, 0);
        do_read();

        // Random frames with random configuration, gaps and reads.
        for (int k = 0; k < 60; k++) begin
            logic [7:0] d;
            logic pe, po, l7, cr, rs;
            d  = 8'($urandom);
            pe = 1'($urandom); po = 1'($urandom); l7 = 1'($urandom);
            cr = 1'($urandom); rs = 1'($urandom);
            send_frame(d, pe, po, l7, cr, rs, $urandom_range(1, 2),
                       $urandom_range(0, 2), 1);
            if ($urandom_range(0, 2) == 0) do_read();
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule